// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a 32-bit timer for a peripheral subsystem. In timer mode a programmable prescaler divides the peripheral clock, and the divided tick advances the main count. In counter mode the prescaler is bypassed. The main count then advances on rising, falling or both edges of one selectable capture input. Each capture input is first synchronised through two flip-flops.

Four match values are compared against the main count at all times. When the count equals a match value on a counting step, the enabled actions for that match take effect: raise its interrupt flag, return the count to zero, and/or stop the timer. Software drives everything through a synchronous word-addressed register port. Writes take effect on the clock edge and reads are combinational.

Register word addresses: 0 control, 1 count mode, 2 prescale limit, 3 prescale count, 4 main count, 5 match actions, 6 interrupt flags, 8 to 11 match values 0 to 3. Addresses 7 and 12 to 15 read as zero.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq` is low.
- R2: In timer mode (count mode bits [1:0] = 00) with the run bit (control bit 0) set and prescale limit N, the prescale count steps 0,1,…,N. On the clock where it equals N it returns to 0 and the main count advances, so the main count advances once every N+1 clocks.
- R3: The main count wraps from 0xFFFFFFFF to 0x00000000, and the wrap alone sets no interrupt flag.
- R4: A counting step with the main count equal to match value i sets interrupt flag i (flags register bit i) when match-action bit 3i is set. `irq` is high whenever any flag is set.
- R5: On a counting step that hits match i with match-action bit 3i+1 set, the main count becomes 0 instead of advancing. The flag is still set if bit 3i is set.
- R6: On a counting step that hits match i with match-action bit 3i+2 set, the run bit clears. Without a reset action the main count stays at the match value, and both counts then hold.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A set arriving in the same cycle wins over the clear.
- R8: While control bit 1 is set, both counts are held at zero. While the run bit is clear, neither count moves.
- R9: Count mode bits [1:0] select 01 rising, 10 falling, 11 both edges of the synchronised capture input. Each detected edge advances the main count by one, and the prescale count does not move.
- R10: Count mode bits [3:2] choose the counted input: 00 capture input 0, 01 capture input 1. Values 10 and 11 count nothing, and edges on the unselected input have no effect.
- R11: Writing the prescale-count or main-count address loads that count, unless control bit 1 is set, in which case the count stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_in | input | 2 | Asynchronous capture inputs |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench targets these corner cases:
- A prescale limit of zero next to larger limits. A design that compared against N+1 or loaded the prescaler one clock late would drift by a cycle on every period.
- A count loaded just below the 32-bit limit and run across the wrap. A design that raised a flag or saturated there would show up on the interrupt line or in the read-back count.
- Match reset and match stop, set separately. A count that ran one past the match value, or a stop that left the run bit set, would break the hold of the count.
- Edge counting on each input and each polarity, including the reserved select codes. A wrong synchroniser depth would shift every count by a clock against the cycle-by-cycle model.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int AW = 4;

    localparam logic [AW-1:0] A_CTRL   = 4'd0;
    localparam logic [AW-1:0] A_MODE   = 4'd1;
    localparam logic [AW-1:0] A_PLIM   = 4'd2;
    localparam logic [AW-1:0] A_PCNT   = 4'd3;
    localparam logic [AW-1:0] A_COUNT  = 4'd4;
    localparam logic [AW-1:0] A_ACT    = 4'd5;
    localparam logic [AW-1:0] A_FLAGS  = 4'd6;
    localparam logic [AW-1:0] A_MATCH0 = 4'd8;

    typedef enum logic [1:0] {
        CM_TIMER = 2'b00,
        CM_RISE  = 2'b01,
        CM_FALL  = 2'b10,
        CM_BOTH  = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        logic stop;
        logic zero;
        logic intr;
    } match_act_t;

    function automatic logic edge_pick(cnt_mode_e m, logic cur, logic prv);
        case (m)
            CM_RISE: return cur & ~prv;
            CM_FALL: return ~cur & prv;
            CM_BOTH: return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mtmr_edge.sv
module mtmr_edge
    import mtmr_pkg::*;
#(
    parameter int NCAP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCAP-1:0] cap,
    input  logic [1:0]      sel,
    input  cnt_mode_e       mode,
    output logic            pulse
);
    logic [NCAP-1:0] sync1, sync2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= cap;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    always_comb begin
        pulse = 1'b0;
        for (int k = 0; k < NCAP; k++) begin
            if (int'(sel) == k) pulse = edge_pick(mode, sync2[k], prev[k]);
        end
    end
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
    import mtmr_pkg::*;
#(
    parameter int W  = 32,
    parameter int NM = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          hold_zero,
    input  logic          timer_mode,
    input  logic          edge_pulse,
    input  logic [W-1:0]  plim,
    input  logic [W-1:0]  mval [NM],
    input  logic [NM-1:0] m_intr,
    input  logic [NM-1:0] m_zero,
    input  logic [NM-1:0] m_stop,
    input  logic          ld_pcnt,
    input  logic          ld_count,
    input  logic [W-1:0]  ld_val,
    input  logic [NM-1:0] flag_clr,
    output logic [W-1:0]  pcnt,
    output logic [W-1:0]  count,
    output logic [NM-1:0] flags,
    output logic [NM-1:0] hit,
    output logic          step,
    output logic          stop_req
);
    logic pdone;
    logic any_zero;

    assign pdone = (pcnt == plim);
    assign step  = run & ~hold_zero & (timer_mode ? pdone : edge_pulse);

    for (genvar i = 0; i < NM; i++) begin : g_cmp
        assign hit[i] = step & (count == mval[i]);
    end

    assign any_zero = |(hit & m_zero);
    assign stop_req = |(hit & m_stop);

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            pcnt <= '0;
        end else if (ld_pcnt) begin
            pcnt <= ld_val;
        end else if (run && timer_mode) begin
            pcnt <= pdone ? '0 : pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            count <= '0;
        end else if (ld_count) begin
            count <= ld_val;
        end else if (step) begin
            if (any_zero)      count <= '0;
            else if (!stop_req) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | (hit & m_intr);
    end
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int W  = 32,
    parameter int NM = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          stop_req,
    input  logic [W-1:0]  pcnt,
    input  logic [W-1:0]  count,
    input  logic [NM-1:0] flags,
    output logic          run,
    output logic          hold_zero,
    output cnt_mode_e     mode,
    output logic [1:0]    sel,
    output logic [W-1:0]  plim,
    output logic [W-1:0]  mval [NM],
    output logic [NM-1:0] m_intr,
    output logic [NM-1:0] m_zero,
    output logic [NM-1:0] m_stop,
    output logic          ld_pcnt,
    output logic          ld_count,
    output logic [NM-1:0] flag_clr
);
    localparam int AWID = 3 * NM;

    logic [AWID-1:0] act;

    assign ld_pcnt  = we && addr == A_PCNT;
    assign ld_count = we && addr == A_COUNT;
    assign flag_clr = (we && addr == A_FLAGS) ? wdata[NM-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            hold_zero <= 1'b0;
            mode      <= CM_TIMER;
            sel       <= '0;
            plim      <= '0;
            act       <= '0;
        end else begin
            if (we && addr == A_CTRL) begin
                run       <= wdata[0];
                hold_zero <= wdata[1];
            end else if (stop_req) begin
                run <= 1'b0;
            end
            if (we && addr == A_MODE) begin
                mode <= cnt_mode_e'(wdata[1:0]);
                sel  <= wdata[3:2];
            end
            if (we && addr == A_PLIM) plim <= wdata;
            if (we && addr == A_ACT)  act  <= wdata[AWID-1:0];
        end
    end

    for (genvar i = 0; i < NM; i++) begin : g_match
        match_act_t a;
        assign a         = match_act_t'(act[3*i +: 3]);
        assign m_intr[i] = a.intr;
        assign m_zero[i] = a.zero;
        assign m_stop[i] = a.stop;

        always_ff @(posedge clk) begin
            if (rst)                                    mval[i] <= '0;
            else if (we && addr == A_MATCH0 + AW'(i))   mval[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = W'({hold_zero, run});
            A_MODE:  rdata = W'({sel, mode});
            A_PLIM:  rdata = plim;
            A_PCNT:  rdata = pcnt;
            A_COUNT: rdata = count;
            A_ACT:   rdata = W'(act);
            A_FLAGS: rdata = W'(flags);
            default: begin
                for (int i = 0; i < NM; i++)
                    if (addr == A_MATCH0 + AW'(i)) rdata = mval[i];
            end
        endcase
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtmr_pkg::*;
#(
    parameter int W    = 32,
    parameter int NM   = 4,
    parameter int NCAP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    input  logic [NCAP-1:0] cap_in,
    output logic            irq
);
    logic          run, hold_zero, edge_pulse, step, stop_req;
    logic          ld_pcnt, ld_count;
    cnt_mode_e     mode;
    logic [1:0]    sel;
    logic [W-1:0]  plim, pcnt, count;
    logic [W-1:0]  mval [NM];
    logic [NM-1:0] m_intr, m_zero, m_stop, flags, hit, flag_clr;

    mtmr_regs #(.W(W), .NM(NM)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .stop_req(stop_req), .pcnt(pcnt), .count(count),
        .flags(flags), .run(run), .hold_zero(hold_zero), .mode(mode), .sel(sel),
        .plim(plim), .mval(mval), .m_intr(m_intr), .m_zero(m_zero),
        .m_stop(m_stop), .ld_pcnt(ld_pcnt), .ld_count(ld_count),
        .flag_clr(flag_clr)
    );

    mtmr_edge #(.NCAP(NCAP)) u_edge (
        .clk(clk), .rst(rst), .cap(cap_in), .sel(sel), .mode(mode),
        .pulse(edge_pulse)
    );

    mtmr_core #(.W(W), .NM(NM)) u_core (
        .clk(clk), .rst(rst), .run(run), .hold_zero(hold_zero),
        .timer_mode(mode == CM_TIMER), .edge_pulse(edge_pulse), .plim(plim),
        .mval(mval), .m_intr(m_intr), .m_zero(m_zero), .m_stop(m_stop),
        .ld_pcnt(ld_pcnt), .ld_count(ld_count), .ld_val(bus_wdata),
        .flag_clr(flag_clr), .pcnt(pcnt), .count(count), .flags(flags),
        .hit(hit), .step(step), .stop_req(stop_req)
    );

    assign irq = |flags;
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk
    import mtmr_pkg::*;
#(
    parameter int W  = 32,
    parameter int NM = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          run,
    input logic          hold_zero,
    input cnt_mode_e     mode,
    input logic [W-1:0]  plim,
    input logic [W-1:0]  pcnt,
    input logic [W-1:0]  count,
    input logic          step,
    input logic [NM-1:0] hit,
    input logic [NM-1:0] m_intr,
    input logic [NM-1:0] m_zero,
    input logic          stop_req,
    input logic [NM-1:0] flags
);
    logic wr_count, wr_ctrl;
    assign wr_count = bus_we && (bus_addr == A_COUNT || bus_addr == A_PCNT);
    assign wr_ctrl  = bus_we && bus_addr == A_CTRL;

    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (rst)
        hold_zero |=> (pcnt == '0 && count == '0));

    assert_prescale_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !hold_zero && mode == CM_TIMER && pcnt != plim && !wr_count)
        |=> $stable(count));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step && count == '1 && hit == '0 && !wr_count && !hold_zero)
        |=> count == '0);

    assert_match_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ((|(hit & m_zero)) && !wr_count && !hold_zero) |=> count == '0);

    assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !wr_ctrl) |=> !run);

    for (genvar i = 0; i < NM; i++) begin : g_flag
        assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && m_intr[i]) |=> flags[i]);
    end
endmodule

bind match_timer mtmr_chk #(.W(W), .NM(NM)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .run(run),
    .hold_zero(hold_zero), .mode(mode), .plim(plim), .pcnt(pcnt),
    .count(count), .step(step), .hit(hit), .m_intr(m_intr), .m_zero(m_zero),
    .stop_req(stop_req), .flags(flags)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
    localparam int W = 32;
    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [3:0]    bus_addr = 4'd4;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [1:0]    cap_in = 2'b00;
    logic          irq;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 0;

    always #10 clk = ~clk;

    match_timer u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
    );

    // behavioural reference
    logic          m_run, m_hz;
    logic [1:0]    m_mode, m_sel;
    logic [W-1:0]  m_plim, m_pc, m_tc;
    logic [11:0]   m_act;
    logic [W-1:0]  m_mv [NM];
    logic [NM-1:0] m_fl;
    logic [1:0]    hq [$];

    function automatic logic [W-1:0] mread(logic [3:0] a);
        case (a)
            4'd0: return W'({m_hz, m_run});
            4'd1: return W'({m_sel, m_mode});
            4'd2: return m_plim;
            4'd3: return m_pc;
            4'd4: return m_tc;
            4'd5: return W'(m_act);
            4'd6: return W'(m_fl);
            4'd8, 4'd9, 4'd10, 4'd11: return m_mv[a - 4'd8];
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_hz = 0; m_mode = 0; m_sel = 0; m_plim = 0;
            m_pc = 0; m_tc = 0; m_act = 0; m_fl = 0;
            for (int i = 0; i < NM; i++) m_mv[i] = 0;
            hq = '{2'b00, 2'b00, 2'b00};
        end else begin
            logic ep, stp, any_z, any_s;
            logic [NM-1:0] h;
            logic [1:0] cur, prv;
            cur = hq[1];
            prv = hq[2];
            ep = 0;
            if (m_sel < 2) begin
                case (m_mode)
                    2'b01: ep = cur[m_sel] && !prv[m_sel];
                    2'b10: ep = !cur[m_sel] && prv[m_sel];
                    2'b11: ep = cur[m_sel] != prv[m_sel];
                    default: ep = 0;
                endcase
            end
            stp = m_run && !m_hz && (m_mode == 0 ? (m_pc == m_plim) : ep);
            any_z = 0; any_s = 0;
            for (int i = 0; i < NM; i++) begin
                h[i] = stp && (m_tc == m_mv[i]);
                if (h[i] && m_act[3*i+1]) any_z = 1;
                if (h[i] && m_act[3*i+2]) any_s = 1;
            end
            // flags
            if (bus_we && bus_addr == 4'd6) m_fl = m_fl & ~bus_wdata[NM-1:0];
            for (int i = 0; i < NM; i++) if (h[i] && m_act[3*i]) m_fl[i] = 1;
            // counts
            if (m_hz) begin
                m_pc = 0; m_tc = 0;
            end else begin
                if (bus_we && bus_addr == 4'd3) m_pc = bus_wdata;
                else if (m_run && m_mode == 0) m_pc = (m_pc == m_plim) ? 0 : m_pc + 1;
                if (bus_we && bus_addr == 4'd4) m_tc = bus_wdata;
                else if (stp) begin
                    if (any_z) m_tc = 0;
                    else if (!any_s) m_tc = m_tc + 1;
                end
            end
            // configuration
            if (bus_we && bus_addr == 4'd0) begin
                m_run = bus_wdata[0]; m_hz = bus_wdata[1];
            end else if (any_s) m_run = 0;
            if (bus_we && bus_addr == 4'd1) begin
                m_mode = bus_wdata[1:0]; m_sel = bus_wdata[3:2];
            end
            if (bus_we && bus_addr == 4'd2) m_plim = bus_wdata;
            if (bus_we && bus_addr == 4'd5) m_act = bus_wdata[11:0];
            for (int i = 0; i < NM; i++)
                if (bus_we && bus_addr == 4'(8 + i)) m_mv[i] = bus_wdata;
            hq.push_front(cap_in);
            void'(hq.pop_back());
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " model rdata"}, bus_rdata, mread(bus_addr));
            check({cur_req, " model irq"}, W'(irq), W'(m_fl != 0));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(logic [3:0] a, logic [W-1:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_we = 0; bus_addr = 4'd4; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 4'd4;
    endtask

    task automatic pulse(int c);
        cap_in[c] = 1; tick(3);
        cap_in[c] = 0; tick(3);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        tick(3);
        rst = 0;
        tick(1);

        // R1: reset state
        cur_req = "R1";
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1 reset read", v, '0);
        end
        check("R1 irq", W'(irq), '0);

        // R2: prescale limit 0 then 2
        cur_req = "R2";
        wr(4'd1, 0); wr(4'd2, 0); wr(4'd0, 1);
        tick(10);
        wr(4'd0, 0);
        rd(4'd4, v);
        check("R2 limit0 count", v, 32'd11);
        wr(4'd0, 2); wr(4'd2, 2); wr(4'd0, 1);
        bus_addr = 4'd3; tick(12); bus_addr = 4'd4; tick(10);
        wr(4'd0, 0);

        // R4/R7: match 0 with interrupt only
        cur_req = "R4";
        wr(4'd0, 2); wr(4'd5, 12'h001); wr(4'd8, 5); wr(4'd0, 1);
        tick(30);
        wr(4'd0, 0);
        rd(4'd6, v); check("R4 flag0", v, 32'h1);
        check("R4 irq high", W'(irq), 32'h1);
        rd(4'd4, v); check("R4 count passes match", W'(v > 5), 32'h1);
        cur_req = "R7";
        wr(4'd6, 0);
        rd(4'd6, v); check("R7 write zero keeps", v, 32'h1);
        wr(4'd6, 1);
        rd(4'd6, v); check("R7 clear", v, 32'h0);
        check("R7 irq low", W'(irq), 32'h0);

        // R5: match 1 resets with interrupt
        cur_req = "R5";
        wr(4'd0, 2); wr(4'd2, 1); wr(4'd5, 12'h018); wr(4'd9, 3); wr(4'd0, 1);
        for (int k = 0; k < 30; k++) begin
            tick(1);
            rd(4'd4, v);
            check("R5 count bounded", W'(v <= 3), 32'h1);
        end
        wr(4'd0, 0);
        rd(4'd6, v); check("R5 flag1", v, 32'h2);
        wr(4'd6, 32'hF);

        // R6: match 2 stops
        cur_req = "R6";
        wr(4'd0, 2); wr(4'd2, 0); wr(4'd5, 12'h100); wr(4'd10, 4); wr(4'd0, 1);
        tick(15);
        rd(4'd4, v); check("R6 held at match", v, 32'd4);
        rd(4'd0, v); check("R6 run cleared", v, 32'd0);
        rd(4'd6, v); check("R6 no flag", v, 32'd0);

        // R3: wrap
        cur_req = "R3";
        wr(4'd5, 0); wr(4'd4, 32'hFFFF_FFFE); wr(4'd0, 1);
        tick(4);
        wr(4'd0, 0);
        rd(4'd4, v); check("R3 wrapped", v, 32'd3);
        check("R3 no irq", W'(irq), 32'h0);

        // R8/R11: hold-zero and loads
        cur_req = "R8";
        wr(4'd2, 3); wr(4'd0, 3); tick(5);
        rd(4'd4, v); check("R8 count zero", v, 32'd0);
        rd(4'd3, v); check("R8 pcnt zero", v, 32'd0);
        cur_req = "R11";
        wr(4'd4, 7);
        rd(4'd4, v); check("R11 load blocked", v, 32'd0);
        wr(4'd0, 0); wr(4'd4, 7); wr(4'd3, 1); tick(3);
        rd(4'd4, v); check("R11 load count", v, 32'd7);
        rd(4'd3, v); check("R11 load pcnt", v, 32'd1);
        cur_req = "R8";
        rd(4'd4, v); check("R8 idle holds", v, 32'd7);

        // R9/R10: counter mode
        cur_req = "R9";
        wr(4'd4, 0); wr(4'd1, 32'h1); wr(4'd0, 1);
        pulse(0); pulse(0); pulse(0); tick(4);
        rd(4'd4, v); check("R9 rising x3", v, 32'd3);
        rd(4'd3, v); check("R9 pcnt still", v, 32'd1);
        wr(4'd1, 32'h2);
        pulse(0); pulse(0); tick(4);
        rd(4'd4, v); check("R9 falling x2", v, 32'd5);
        cur_req = "R10";
        wr(4'd1, 32'h7);
        pulse(1); pulse(1); pulse(0); tick(4);
        rd(4'd4, v); check("R10 both on input1", v, 32'd9);
        wr(4'd1, 32'h9);
        pulse(0); pulse(1); tick(4);
        rd(4'd4, v); check("R10 reserved select", v, 32'd9);
        wr(4'd1, 32'hD);
        pulse(0); pulse(1); tick(4);
        rd(4'd4, v); check("R10 reserved select 11", v, 32'd9);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule